// File: doc/BRIEF.md
# Cascadable Slave Serial Result Shifter

This block hands a held 16-bit conversion result to a host over a serial link whose clock comes from the host. The host selects the block by pulling chip select and the read strobe low, then supplies clock pulses. The block answers with one bit per pulse, most significant bit first. The serial clock, the selects and the cascade input are sampled by the system clock, which must run well above the serial clock. Internally the design works only on detected edges, so a clock that runs all the time and a gated clock that idles high or low are handled alike.

Several devices can share one clock and one select, chained in a line. Each device takes the output of its upstream neighbour on a cascade input. That input is sampled on the rising edge and shifted in behind the local word on the falling edge. Once the local word is out, the upstream word follows on the next pulses.

A result can be read in two ways. The host can read it after the conversion has ended. It can also read the previous result while the next conversion runs. In that second case the cascade input is ignored. If a read has started but 16 bits have not been clocked out when the conversion ends, the block raises a one-cycle read-error pulse.

Top module: `cascade_ser_out`

## Requirements
- R1: Bits move only while cs_n and rd_n are both low. With either one high, sclk edges have no effect and sdout is held low.
- R2: Each selection starts at the MSB of the held 16-bit word. The host samples on the rising edge. The next bit is presented after each falling edge that follows a rising edge within the same selection.
- R3: sdin is sampled on each rising edge and shifted in behind the word on the following falling edge. Bit 17 of a selection is the first sdin bit, so 32 pulses read the local word followed by the upstream word.
- R4: While busy is high, zeros are shifted in and sdin is ignored.
- R5: A res_load pulse stores res_data as pending. When busy falls, the held word takes the pending value, or res_data if res_load arrives in that same cycle. A read while busy is high returns the previously held word.
- R6: rd_err is high for exactly one system clock cycle, the cycle after busy is first sampled low. It pulses only when, during that conversion, a read clocked at least one rising edge but never reached 16 rising edges counted from one selection start. It stays low when no read was attempted and when a read completed.
- R7: Raising cs_n or rd_n mid-transfer aborts it. The next selection restarts at the MSB and its bit count starts again from zero.
- R8: A gated sclk may idle high or low. A falling edge that comes before any rising edge in a selection is ignored. sclk must stay high and low for at least two system clock periods each, which allows 40 MHz at a 200 MHz system clock.
- R9: After reset, sdout and rd_err are low and the held word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| sdin | input | 1 | Cascade input from the upstream device |
| busy | input | 1 | High while a conversion runs |
| res_load | input | 1 | Pulse: res_data holds a new result |
| res_data | input | 16 | New conversion result |
| sdout | output | 1 | Serial data out |
| rd_err | output | 1 | One-cycle pulse: read during conversion left incomplete |

## Verification
Two events can land in the same system cycle: the end of a conversion, where busy falls, and the arrival of a new result on res_load. The bench drives both on one clock edge. It then reads the block and expects the new word, not the older pending one. The end of a conversion can also meet a read that is still in progress. Random runs stop reads during conversion after 1 to 15 bits, sometimes with a deselect in between. For each conversion, the bench counts rd_err high cycles and compares that count with a model that expects one cycle only for an incomplete read.

// File: rtl/slvsh_pkg.sv
package slvsh_pkg;

    // Host pins after synchronisation into the system clock domain
    typedef struct packed {
        logic sclk;
        logic cs_n;
        logic rd_n;
        logic sdin;
    } pins_t;

    localparam pins_t PINS_IDLE = '{sclk: 1'b0, cs_n: 1'b1, rd_n: 1'b1, sdin: 1'b0};

endpackage

// File: rtl/slvsh_sync.sv
module slvsh_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/slvsh_edge.sv
module slvsh_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic cs_n_s,
    input  logic rd_n_s,
    output logic act,
    output logic start,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic sclk;
        logic act;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        act      = !cs_n_s && !rd_n_s;
        start    = act && !st_q.act;
        rise     = act && st_q.act && sclk_s && !st_q.sclk;
        fall     = act && st_q.act && !sclk_s && st_q.sclk;
        st_d.sclk = sclk_s;
        st_d.act  = act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/slvsh_shift.sv
module slvsh_shift #(
    parameter int DW = 16,
    localparam int CW = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act,
    input  logic          start,
    input  logic          rise,
    input  logic          fall,
    input  logic          sdin_s,
    input  logic          busy,
    input  logic          upd,
    input  logic [DW-1:0] upd_word,
    input  logic [DW-1:0] hold_word,
    output logic          sdout,
    output logic          tick,
    output logic          done,
    output logic [CW-1:0] cnt_o
);
    typedef struct packed {
        logic [DW-1:0] sr;
        logic          cap;
        logic [CW-1:0] cnt;
        logic          armed;
    } shf_st_t;

    shf_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        done = 1'b0;
        if (upd) begin
            st_d.sr    = upd_word;
            st_d.cnt   = '0;
            st_d.armed = 1'b0;
        end else if (start) begin
            st_d.sr    = hold_word;
            st_d.cnt   = '0;
            st_d.armed = 1'b0;
        end else if (act) begin
            if (rise) begin
                st_d.cap   = sdin_s && !busy;
                st_d.armed = 1'b1;
                if (st_q.cnt != CW'(DW)) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                    tick     = 1'b1;
                    done     = (st_q.cnt == CW'(DW - 1));
                end
            end else if (fall && st_q.armed) begin
                st_d.sr = {st_q.sr[DW-2:0], st_q.cap};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdout = act && st_q.sr[DW-1];
    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/slvsh_conv.sv
module slvsh_conv #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          res_load,
    input  logic [DW-1:0] res_data,
    input  logic          tick,
    input  logic          done,
    output logic          upd,
    output logic [DW-1:0] upd_word,
    output logic [DW-1:0] hold_word,
    output logic          rd_err
);
    typedef struct packed {
        logic [DW-1:0] pend;
        logic [DW-1:0] hold;
        logic          busy;
        logic          started;
        logic          err;
    } conv_st_t;

    conv_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        upd       = !busy && st_q.busy;
        upd_word  = res_load ? res_data : st_q.pend;
        st_d.busy = busy;
        st_d.pend = upd_word;
        st_d.err  = 1'b0;
        if (upd) begin
            st_d.hold    = upd_word;
            st_d.started = 1'b0;
            st_d.err     = st_q.started;
        end else if (busy && tick) begin
            st_d.started = !done;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_word = st_q.hold;
    assign rd_err    = st_q.err;
endmodule

// File: rtl/cascade_ser_out.sv
module cascade_ser_out #(
    parameter int DW         = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          sdin,
    input  logic          busy,
    input  logic          res_load,
    input  logic [DW-1:0] res_data,
    output logic          sdout,
    output logic          rd_err
);
    import slvsh_pkg::*;

    localparam int CW = $clog2(DW + 1);
    localparam int PW = $bits(pins_t);

    pins_t          pins_raw, pins_s;
    logic           act, start, rise, fall;
    logic           tick, done, upd;
    logic [DW-1:0]  upd_word, hold_word;
    logic [CW-1:0]  bit_cnt;

    assign pins_raw = '{sclk: sclk, cs_n: cs_n, rd_n: rd_n, sdin: sdin};

    slvsh_sync #(.W(PW), .STAGES(SYNC_DEPTH), .RST_VAL(PINS_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
    );

    slvsh_edge u_edge (
        .clk(clk), .rst_n(rst_n),
        .sclk_s(pins_s.sclk), .cs_n_s(pins_s.cs_n), .rd_n_s(pins_s.rd_n),
        .act(act), .start(start), .rise(rise), .fall(fall)
    );

    slvsh_shift #(.DW(DW)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .act(act), .start(start), .rise(rise), .fall(fall),
        .sdin_s(pins_s.sdin), .busy(busy),
        .upd(upd), .upd_word(upd_word), .hold_word(hold_word),
        .sdout(sdout), .tick(tick), .done(done), .cnt_o(bit_cnt)
    );

    slvsh_conv #(.DW(DW)) u_conv (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .res_load(res_load), .res_data(res_data),
        .tick(tick), .done(done),
        .upd(upd), .upd_word(upd_word), .hold_word(hold_word),
        .rd_err(rd_err)
    );
endmodule

// File: rtl/cascade_ser_out_chk.sv
module cascade_ser_out_chk #(
    parameter int DW = 16,
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          rd_err,
    input logic          sdout,
    input logic          act,
    input logic          upd,
    input logic [DW-1:0] upd_word,
    input logic [CW-1:0] bit_cnt
);
    // R6: error pulse lasts one cycle
    p_err_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |=> !rd_err);

    // R6: error pulse follows the cycle in which busy was first seen low
    p_err_after_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (!$past(busy) && $past(busy, 2)));

    // R1: with no selection and no new result the bit count cannot move
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && !upd) |=> $stable(bit_cnt));

    // R5: a result taken at end of conversion shows its MSB while still selected
    p_load_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && act) |=> (!act || (sdout == $past(upd_word[DW-1]))));
endmodule

bind cascade_ser_out cascade_ser_out_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .rd_err(rd_err), .sdout(sdout),
    .act(act), .upd(upd), .upd_word(upd_word), .bit_cnt(bit_cnt)
);

// File: tb/cascade_ser_out_tb_top.sv
`timescale 1ns/1ps
module cascade_ser_out_tb_top;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sclk = 1'b0, cs_n = 1'b1, rd_n = 1'b1, sdin = 1'b0;
    logic          busy = 1'b0, res_load = 1'b0;
    logic [DW-1:0] res_data = '0;
    logic          sdout, rd_err;

    int n_chk = 0, n_fail = 0, err_cnt = 0;
    bit finished = 0;
    logic [DW-1:0] hold_m = '0, pend_m = '0;

    always #2.5 clk = ~clk;

    cascade_ser_out #(.DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .rd_n(rd_n),
        .sdin(sdin), .busy(busy), .res_load(res_load), .res_data(res_data),
        .sdout(sdout), .rd_err(rd_err)
    );

    always @(posedge clk) if (rd_err) err_cnt++;

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
        n_chk++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
        end
    endtask

    // expected first n bits of a selection: local word, then cascade or zeros
    function automatic logic [31:0] exp_bits(input logic [15:0] w, input logic [15:0] up,
                                             input logic bsy, input int n);
        logic [31:0] full;
        full = {w, bsy ? 16'h0 : up};
        return full >> (32 - n);
    endfunction

    task automatic xfer(input bit idle_hi, input int nbits, input int hp,
                        input logic [15:0] up, output logic [31:0] got);
        got = '0;
        sclk = idle_hi;
        wait_cyc(1);
        cs_n = 1'b0; rd_n = 1'b0;
        wait_cyc(5);
        if (idle_hi) begin
            sclk = 1'b0;
            wait_cyc(hp);
        end
        for (int k = 0; k < nbits; k++) begin
            sdin = (k < 16) ? up[15-k] : 1'b0;
            wait_cyc(hp);
            sclk = 1'b1;
            wait_cyc(hp);
            got = {got[30:0], sdout};
            sclk = 1'b0;
        end
        wait_cyc(hp);
        cs_n = 1'b1; rd_n = 1'b1;
        wait_cyc(1);
        sclk = idle_hi;
        wait_cyc(4);
    endtask

    task automatic conv_begin(input logic [15:0] w);
        busy = 1'b1;
        wait_cyc(2);
        res_data = w; res_load = 1'b1;
        wait_cyc(1);
        res_load = 1'b0;
        pend_m = w;
    endtask

    task automatic conv_end(input int exp_err, input string req);
        int e0;
        e0 = err_cnt;
        busy = 1'b0;
        wait_cyc(5);
        hold_m = pend_m;
        chk(req, err_cnt - e0, exp_err);
    endtask

    initial begin
        logic [31:0] got;
        logic [15:0] w, up;
        int e0, mode, nb, hp;
        bit ih;
        void'($urandom(32'd4242));

        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        chk("R9 sdout", sdout, 0);
        chk("R9 rd_err", rd_err, 0);
        xfer(0, 16, 3, 16'hFFFF, got);
        chk("R9 held zero", got, 0);

        conv_begin(16'hA5C3);
        conv_end(0, "R6 no read");
        xfer(0, 16, 3, 16'h0, got);
        chk("R2 idle-low read", got, exp_bits(hold_m, 0, 0, 16));
        xfer(1, 16, 2, 16'h0, got);
        chk("R8 idle-high fast read", got, exp_bits(hold_m, 0, 0, 16));
        xfer(0, 32, 2, 16'h3C5A, got);
        chk("R3 cascade 32 bits", got, exp_bits(hold_m, 16'h3C5A, 0, 32));

        // R1: clocks with only one select active
        cs_n = 1'b1; rd_n = 1'b0;
        for (int k = 0; k < 6; k++) begin
            sclk = 1'b1; wait_cyc(3); sclk = 1'b0; wait_cyc(3);
            chk("R1 cs high sdout", sdout, 0);
        end
        cs_n = 1'b0; rd_n = 1'b1;
        for (int k = 0; k < 6; k++) begin
            sclk = 1'b1; wait_cyc(3); sclk = 1'b0; wait_cyc(3);
            chk("R1 rd high sdout", sdout, 0);
        end
        cs_n = 1'b1; rd_n = 1'b1;
        wait_cyc(4);
        xfer(0, 16, 3, 16'h0, got);
        chk("R1 word intact", got, exp_bits(hold_m, 0, 0, 16));

        // R4/R5: read previous word during conversion, cascade ignored
        conv_begin(16'h1234);
        xfer(0, 32, 3, 16'hFFFF, got);
        chk("R4 R5 read during conv", got, exp_bits(hold_m, 16'hFFFF, 1, 32));
        conv_end(0, "R6 complete read");

        // R6: partial read during conversion, R1 clocks while deselected do not count
        conv_begin(16'h8001);
        xfer(1, 8, 3, 16'h0, got);
        chk("R6 partial bits", got, exp_bits(hold_m, 0, 1, 8));
        cs_n = 1'b1;
        for (int k = 0; k < 10; k++) begin
            sclk = 1'b1; wait_cyc(2); sclk = 1'b0; wait_cyc(2);
        end
        conv_end(1, "R6 R1 incomplete read error");

        // R7: abort then restart from MSB
        conv_begin(16'h0F0F);
        xfer(0, 5, 2, 16'h0, got);
        xfer(0, 16, 2, 16'h0, got);
        chk("R7 restart at MSB", got, exp_bits(hold_m, 0, 1, 16));
        conv_end(0, "R7 full reread clears error");
        xfer(1, 7, 3, 16'h0, got);
        xfer(1, 16, 3, 16'h0, got);
        chk("R7 abort after conv", got, exp_bits(hold_m, 0, 0, 16));

        // R5: result arrives in the very cycle busy falls
        busy = 1'b1; res_data = 16'h7777; res_load = 1'b1;
        wait_cyc(1);
        res_load = 1'b0;
        wait_cyc(3);
        busy = 1'b0; res_data = 16'hC0DE; res_load = 1'b1;
        wait_cyc(1);
        res_load = 1'b0;
        hold_m = 16'hC0DE; pend_m = 16'hC0DE;
        wait_cyc(4);
        xfer(0, 16, 3, 16'h0, got);
        chk("R5 same-cycle load", got, exp_bits(hold_m, 0, 0, 16));

        // random mix
        for (int it = 0; it < 40; it++) begin
            w  = 16'($urandom);
            conv_begin(w);
            mode = int'($urandom % 3);
            hp = 2 + int'($urandom % 4);
            ih = 1'($urandom);
            up = 16'($urandom);
            if (mode == 1) begin
                nb = 1 + int'($urandom % 15);
                xfer(ih, nb, hp, up, got);
                chk("R6 rand partial bits", got, exp_bits(hold_m, up, 1, nb));
            end else if (mode == 2) begin
                nb = 16 + int'($urandom % 17);
                xfer(ih, nb, hp, up, got);
                chk("R4 rand conv read", got, exp_bits(hold_m, up, 1, nb));
            end
            conv_end((mode == 1) ? 1 : 0, "R6 rand error count");
            nb = 1 + int'($urandom % 32);
            hp = 2 + int'($urandom % 4);
            ih = 1'($urandom);
            up = 16'($urandom);
            xfer(ih, nb, hp, up, got);
            chk("R3 rand after-conv read", got, exp_bits(hold_m, up, 0, nb));
        end

        e0 = err_cnt;
        chk("R6 no stray error", err_cnt - e0, 0);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule